// File: doc/BRIEF.md
# Shadowed-Hop Phase Accumulator

This block is the phase engine of a digital tuner channel. It is a phase accumulator that adds a frequency word to its phase on every enabled sample, modulo 2^FREQ_W. The frequency word is loaded by software in 16-bit halves. The halves land in a shadow register, so loading them never disturbs the running oscillator. The shadow is copied into the working frequency register only at a commit. A commit is one of three things: a hop strobe from the sync logic, the channel waking from sleep, or a shadow write while the immediate-hop input is high.

A mode input sets what happens to the phase at a commit. With the mode low, the hop is phase-continuous. With the mode high, the phase restarts from zero.

A two-state controller tracks the channel. In `ST_ASLEEP` the phase holds. The transition from `ST_ASLEEP` to `ST_RUN` is the wake, taken on the first cycle in which `sleep` is low; that cycle commits the shadow and does not advance. The transition from `ST_RUN` to `ST_ASLEEP` is taken on any cycle in which `sleep` is high. Both states hold when their input is unchanged.

Top module: `nco_hop_core`

## Requirements
- R1: A write with `wr_sel`=0 loads bits 15:0 of the shadow word, and a write with `wr_sel`=1 loads bits 31:16. The half that is not selected keeps its value.
- R2: A shadow write without a commit leaves the working frequency unchanged, so the phase keeps stepping by the old word.
- R3: In a running cycle with `clk_en` high and `sleep` low, the phase grows by the working word modulo 2^32. With `clk_en` low, the phase holds.
- R4: When `hop_strobe` is high and `hop_clear_mode` is 0, the commit cycle still adds the old word, and the new word is added from the next cycle on.
- R5: At any commit with `hop_clear_mode`=1, the phase becomes zero, and accumulation restarts from zero with the new word.
- R6: In every cycle with `sleep` high, the phase holds. The first cycle with `sleep` low after sleeping commits the shadow and does not advance the phase.
- R7: A shadow write with `hop_immediate` high commits at the same edge, and the working word includes the data being written.
- R8: Both halves written before a commit are placed in the working word at one edge, so no mixed word is ever accumulated.
- R9: Reset clears the phase, the working word and the shadow to zero, and leaves the channel in `ST_ASLEEP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 1 | Half select: 0 low half, 1 high half |
| wr_data | input | 16 | Data for the selected half |
| hop_strobe | input | 1 | Commit request from the sync logic |
| hop_immediate | input | 1 | When high, every shadow write also commits |
| hop_clear_mode | input | 1 | 1 clears the phase at a commit |
| sleep | input | 1 | Channel sleep request |
| clk_en | input | 1 | Sample enable for the accumulator |
| phase_out | output | 32 | Accumulator phase |

## Verification
A wrong working word shows on `phase_out` one enabled cycle after the faulty commit, as a step of the wrong size. Every later step keeps that error, so a stuck or torn commit shows up within two samples. A wrong controller state shows in the wake cycle: an extra advance, or a hop that does not take effect, changes the phase at the next edge. A missing clear shows as a nonzero phase right after a clearing commit.

// File: rtl/nco_hop_pkg.sv
package nco_hop_pkg;

    // Channel activity state
    typedef enum logic [0:0] {
        ST_ASLEEP = 1'b0,
        ST_RUN    = 1'b1
    } chan_state_e;

endpackage

// File: rtl/nco_shadow_regs.sv
module nco_shadow_regs #(
    parameter int FREQ_W    = 32,
    parameter int HALF_W    = 16,
    parameter int NUM_PARTS = FREQ_W / HALF_W,
    parameter int SEL_W     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    output logic [FREQ_W-1:0] shadow_q,
    output logic [FREQ_W-1:0] shadow_d
);

    // One register per part of the word; shadow_d is the value after this edge
    for (genvar g = 0; g < NUM_PARTS; g++) begin : g_part
        logic              hit;
        logic [HALF_W-1:0] part_q;
        logic [HALF_W-1:0] part_d;

        assign hit    = wr_en && (wr_sel == SEL_W'(g));
        assign part_d = hit ? wr_data : part_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                part_q <= '0;
            end else begin
                part_q <= part_d;
            end
        end

        assign shadow_q[g*HALF_W +: HALF_W] = part_q;
        assign shadow_d[g*HALF_W +: HALF_W] = part_d;
    end

endmodule

// File: rtl/nco_commit_ctrl.sv
module nco_commit_ctrl
    import nco_hop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep,
    input  logic        clk_en,
    input  logic        hop_strobe,
    input  logic        wr_en,
    input  logic        hop_immediate,
    output logic        commit,
    output logic        advance,
    output chan_state_e state_o
);

    chan_state_e state_q;
    chan_state_e state_d;
    logic        wake;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ASLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ASLEEP: state_d = sleep ? ST_ASLEEP : ST_RUN;
            ST_RUN:    state_d = sleep ? ST_ASLEEP : ST_RUN;
            default:   state_d = ST_ASLEEP;
        endcase
    end

    // Outputs
    always_comb begin
        wake    = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_ASLEEP: wake    = !sleep;
            ST_RUN:    advance = clk_en && !sleep;
            default: begin
                wake    = 1'b0;
                advance = 1'b0;
            end
        endcase
        commit = wake || hop_strobe || (wr_en && hop_immediate);
    end

    assign state_o = state_q;

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              clear_mode,
    input  logic              advance,
    input  logic [FREQ_W-1:0] load_word,
    output logic [FREQ_W-1:0] work_freq,
    output logic [FREQ_W-1:0] phase
);

    // Working frequency register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_freq <= '0;
        end else if (commit) begin
            work_freq <= load_word;
        end
    end

    // Accumulator: a clearing commit wins over the step, and a step uses the old word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (commit && clear_mode) begin
            phase <= '0;
        end else if (advance) begin
            phase <= phase + work_freq;
        end
    end

endmodule

// File: rtl/nco_hop_core.sv
module nco_hop_core
    import nco_hop_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int HALF_W = 16,
    localparam int NUM_PARTS = FREQ_W / HALF_W,
    localparam int SEL_W     = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              hop_strobe,
    input  logic              hop_immediate,
    input  logic              hop_clear_mode,
    input  logic              sleep,
    input  logic              clk_en,
    output logic [FREQ_W-1:0] phase_out
);

    logic [FREQ_W-1:0] shadow_word;
    logic [FREQ_W-1:0] shadow_next;
    logic [FREQ_W-1:0] work_freq;
    logic              commit;
    logic              advance;
    chan_state_e       chan_state;

    nco_shadow_regs #(
        .FREQ_W    (FREQ_W),
        .HALF_W    (HALF_W),
        .NUM_PARTS (NUM_PARTS),
        .SEL_W     (SEL_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .shadow_q (shadow_word),
        .shadow_d (shadow_next)
    );

    nco_commit_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep         (sleep),
        .clk_en        (clk_en),
        .hop_strobe    (hop_strobe),
        .wr_en         (wr_en),
        .hop_immediate (hop_immediate),
        .commit        (commit),
        .advance       (advance),
        .state_o       (chan_state)
    );

    nco_phase_acc #(
        .FREQ_W (FREQ_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .clear_mode (hop_clear_mode),
        .advance    (advance),
        .load_word  (shadow_next),
        .work_freq  (work_freq),
        .phase      (phase_out)
    );

endmodule

// File: rtl/nco_hop_checker.sv
module nco_hop_checker #(
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              clear_mode,
    input logic              sleep,
    input logic [FREQ_W-1:0] work_freq,
    input logic [FREQ_W-1:0] shadow_word,
    input logic [FREQ_W-1:0] phase
);

    // R2: the working word moves only at a commit
    p_work_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(work_freq));

    // R8: after a commit, the working word equals the whole shadow word
    p_commit_whole_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (work_freq == shadow_word));

    // R5: a clearing commit leaves the phase at zero
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && clear_mode) |=> (phase == '0));

    // R6: a sleeping cycle does not move the phase unless a clear happens
    p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !(commit && clear_mode)) |=> $stable(phase));

endmodule

bind nco_hop_core nco_hop_checker #(.FREQ_W(FREQ_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .clear_mode  (hop_clear_mode),
    .sleep       (sleep),
    .work_freq   (work_freq),
    .shadow_word (shadow_word),
    .phase       (phase_out)
);

// File: tb/nco_hop_core_test.sv
`timescale 1ns/1ps
module nco_hop_core_test;

    typedef struct packed {
        logic        we;
        logic        sel;
        logic [15:0] data;
        logic        hop;
        logic        slp;
        logic        en;
        logic        mode;
        logic        imm;
        logic [31:0] exp;
        logic [15:0] tag;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b1, 1'b0, 16'h0010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0000, "R6"},
        '{1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0000, "R6"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, "R6"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0010, "R3"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0020, "R3"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0020, "R3"},
        '{1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0030, "R2"},
        '{1'b1, 1'b1, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0040, "R2"},
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0050, "R4"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0001_0051, "R8"},
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, "R5"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0001_0001, "R5"},
        '{1'b1, 1'b0, 16'h0002, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0002_0002, "R7"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0003_0004, "R7"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0003_0004, "R6"},
        '{1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0003_0004, "R6"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0003_0004, "R6"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0002_0006, "R3"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0002_0006, "R6"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, "R5"},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_0002, "R1"}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        hop_strobe = 1'b0;
    logic        hop_immediate = 1'b0;
    logic        hop_clear_mode = 1'b0;
    logic        sleep = 1'b1;
    logic        clk_en = 1'b0;
    logic [31:0] phase_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nco_hop_core uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_sel         (wr_sel),
        .wr_data        (wr_data),
        .hop_strobe     (hop_strobe),
        .hop_immediate  (hop_immediate),
        .hop_clear_mode (hop_clear_mode),
        .sleep          (sleep),
        .clk_en         (clk_en),
        .phase_out      (phase_out)
    );

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (phase_out !== exp) begin
            errors++;
            $display("FAIL %s: phase_out=%h expected=%h", req, phase_out, exp);
        end
    endtask

    task automatic drive_idle();
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        hop_strobe = 1'b0; hop_immediate = 1'b0; hop_clear_mode = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected=<5000", cycles);
            finish_run();
        end
    end

    initial begin
        drive_idle();
        sleep = 1'b1;
        clk_en = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R9", 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: one row per cycle, sampled just after the edge
        for (int i = 0; i < NVEC; i++) begin
            wr_en          = VECS[i].we;
            wr_sel         = VECS[i].sel;
            wr_data        = VECS[i].data;
            hop_strobe     = VECS[i].hop;
            sleep          = VECS[i].slp;
            clk_en         = VECS[i].en;
            hop_clear_mode = VECS[i].mode;
            hop_immediate  = VECS[i].imm;
            @(posedge clk);
            #1;
            check($sformatf("%s row %0d", VECS[i].tag, i), VECS[i].exp);
            @(negedge clk);
        end

        // R9: a reset in mid-run clears the phase, the working word and the shadow
        drive_idle();
        sleep = 1'b0;
        clk_en = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 mid-run reset", 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R9 wake after reset", 32'h0);
        @(posedge clk);
        #1;
        check("R9 working word zero", 32'h0);
        @(negedge clk);

        // R9: the channel leaves reset asleep, so the first low-sleep cycle is a wake
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0005;
        @(posedge clk);
        #1;
        check("R9 no advance on wake", 32'h0);
        @(negedge clk);
        drive_idle();
        @(posedge clk);
        #1;
        check("R6 wake committed write", 32'h0000_0005);
        @(negedge clk);

        // R5: a clearing hop while asleep zeroes the phase
        sleep = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hop_strobe = 1'b1; hop_clear_mode = 1'b1;
        @(posedge clk);
        #1;
        check("R5 clear while asleep", 32'h0);
        @(negedge clk);
        drive_idle();

        finish_run();
    end

endmodule